// File: doc/BRIEF.md
# Quad DAC Double-Buffered Register Front End

This block is the digital register interface of a four-channel, 12-bit voltage-output converter. A host writes a 16-bit word through a three-wire serial port: a serial clock, a data line and an active-low chip select. The word carries a two-bit channel address and a 12-bit code. Two active-low, level-sensitive strobes move data through two register ranks. The first strobe makes the input register of the addressed channel follow the shifted code. The second strobe makes all four output registers follow their input registers at the same time, so the four channels change together.

An asynchronous, active-low reset forces every input and output register to a preset code. A select pin chooses the preset: zero-scale or mid-scale. The block runs on a system clock. The transparent latches are modelled as registers that reload on every clock while their strobe is low. All serial and strobe inputs pass through a two-stage synchronizer before they are used.

Top module: `quad_dac_regif`

## Requirements
- R1: While `rst_n` is low, every input register and every output code is 0x000 when `rst_mid` is low. This takes effect without a clock edge.
- R2: While `rst_n` is low, every input register and every output code is 0x800 when `rst_mid` is high.
- R3: A frame is 16 bits, shifted MSB first on rising `sclk` edges while `cs_n` is low. Bits [13:12] select the channel (0=A, 1=B, 2=C, 3=D). Bits [11:0] are the code. Bits [15:14] have no effect.
- R4: Rising `sclk` edges while `cs_n` is high leave the shifted word unchanged. After `cs_n` rises, the word stays usable for any later load.
- R5: While `ld_in_n` is low, only the addressed channel's input register takes the shifted code. The other channels keep their values.
- R6: While `ld_in_n` is high, no input register changes, even when a new frame is shifted in.
- R7: While `ld_out_n` is low, all four output codes take their input registers together. While it is high, the output codes hold.
- R8: With `ld_out_n` held low, a new code reaches the output of the addressed channel no later than the fourth clock edge after `ld_in_n` goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rst_mid | input | 1 | Reset preset select: 0 gives zero-scale, 1 gives mid-scale |
| sclk | input | 1 | Serial clock; bits are taken on its rising edge |
| sdi | input | 1 | Serial data, MSB first |
| cs_n | input | 1 | Frame select, active low |
| ld_in_n | input | 1 | Input register load strobe, active low, level sensitive |
| ld_out_n | input | 1 | Output register load strobe, active low, level sensitive |
| dac_code | output | 48 | Output codes; channel A in [11:0], B in [23:12], C in [35:24], D in [47:36] |

## Verification
The bench builds the block with its default parameters: 12-bit codes, a 2-bit address, a 16-bit frame and a two-stage synchronizer. With a 16-bit frame, the two ignored top bits can be set to ones to show they have no effect. The fixed synchronizer depth makes the latency of the flow-through path a known number of edges, so R8 can be checked on an exact cycle. The 12-bit width makes mid-scale 0x800. That value differs from zero-scale in a single bit, so the two reset presets are easy to tell apart.

// File: rtl/quad_dac_regif.sv
module quad_dac_regif #(
  parameter int CW   = 12,
  parameter int AW   = 2,
  parameter int FW   = 16,
  parameter int SYNC = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     rst_mid,
  input  logic                     sclk,
  input  logic                     sdi,
  input  logic                     cs_n,
  input  logic                     ld_in_n,
  input  logic                     ld_out_n,
  output logic [(1<<AW)*CW-1:0]    dac_code
);
  localparam int NCH = 1 << AW;
  localparam logic [CW-1:0] MID = {1'b1, {(CW-1){1'b0}}};

  logic [CW-1:0] preset;
  logic [SYNC-1:0] sclk_sy, sdi_sy, cs_sy, ldi_sy, ldo_sy;
  logic sclk_q;
  logic [FW-1:0] shreg;
  logic shift_en, ldi, ldo, cs_hi;
  logic [AW-1:0] addr;
  logic [CW-1:0] code;
  logic [CW-1:0] in_q  [NCH];
  logic [CW-1:0] out_q [NCH];

  assign preset   = rst_mid ? MID : '0;
  assign ldi      = ldi_sy[SYNC-1];
  assign ldo      = ldo_sy[SYNC-1];
  assign cs_hi    = cs_sy[SYNC-1];
  assign shift_en = sclk_sy[SYNC-1] & ~sclk_q & ~cs_hi;
  assign addr     = shreg[CW+AW-1:CW];
  assign code     = shreg[CW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_sy <= '0;
      sdi_sy  <= '0;
      cs_sy   <= '1;
      ldi_sy  <= '1;
      ldo_sy  <= '1;
      sclk_q  <= 1'b0;
      shreg   <= '0;
    end else begin
      sclk_sy <= {sclk_sy[SYNC-2:0], sclk};
      sdi_sy  <= {sdi_sy[SYNC-2:0], sdi};
      cs_sy   <= {cs_sy[SYNC-2:0], cs_n};
      ldi_sy  <= {ldi_sy[SYNC-2:0], ld_in_n};
      ldo_sy  <= {ldo_sy[SYNC-2:0], ld_out_n};
      sclk_q  <= sclk_sy[SYNC-1];
      if (shift_en) shreg <= {shreg[FW-2:0], sdi_sy[SYNC-1]};
    end
  end

  a_r4_cs_high_holds: assert property (@(posedge clk) disable iff (!rst_n)
    cs_hi |=> $stable(shreg));

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        in_q[i]  <= preset;
        out_q[i] <= preset;
      end else begin
        if (!ldi && addr == AW'(i)) in_q[i] <= code;
        if (!ldo) out_q[i] <= in_q[i];
      end
    end
    assign dac_code[i*CW +: CW] = out_q[i];

    a_r1_r2_reset_code: assert property (@(posedge clk)
      (!rst_n && $past(!rst_n) && $stable(rst_mid)) |->
      (out_q[i] == (rst_mid ? MID : '0) && in_q[i] == out_q[i]));
    a_r5_addressed_load: assert property (@(posedge clk) disable iff (!rst_n)
      (!ldi && addr == AW'(i)) |=> in_q[i] == $past(code));
    a_r5_others_keep: assert property (@(posedge clk) disable iff (!rst_n)
      (!ldi && addr != AW'(i)) |=> $stable(in_q[i]));
    a_r6_input_hold: assert property (@(posedge clk) disable iff (!rst_n)
      ldi |=> $stable(in_q[i]));
    a_r7_output_follow: assert property (@(posedge clk) disable iff (!rst_n)
      !ldo |=> out_q[i] == $past(in_q[i]));
    a_r7_output_hold: assert property (@(posedge clk) disable iff (!rst_n)
      ldo |=> $stable(out_q[i]));
  end
endmodule

// File: tb/quad_dac_regif_test.sv
module quad_dac_regif_test;
  logic clk = 1'b0;
  logic rst_n, rst_mid, sclk, sdi, cs_n, ld_in_n, ld_out_n;
  logic [47:0] dac_code;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  quad_dac_regif uut (
    .clk(clk), .rst_n(rst_n), .rst_mid(rst_mid), .sclk(sclk), .sdi(sdi),
    .cs_n(cs_n), .ld_in_n(ld_in_n), .ld_out_n(ld_out_n), .dac_code(dac_code)
  );

  task automatic chk(input logic [11:0] act, input logic [11:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %03h expected %03h", what, act, exp);
    end
  endtask

  task automatic chk_all(input logic [11:0] e0, e1, e2, e3, input string req);
    chk(dac_code[11:0],  e0, {req, " ch A"});
    chk(dac_code[23:12], e1, {req, " ch B"});
    chk(dac_code[35:24], e2, {req, " ch C"});
    chk(dac_code[47:36], e3, {req, " ch D"});
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [15:0] w);
    cs_n = 1'b0; wclk(4);
    for (int b = 15; b >= 0; b--) begin
      sdi = w[b]; wclk(4);
      sclk = 1'b1; wclk(4);
      sclk = 1'b0;
    end
    wclk(4); cs_n = 1'b1; wclk(6);
  endtask

  task automatic pulse_in;
    ld_in_n = 1'b0; wclk(6); ld_in_n = 1'b1; wclk(6);
  endtask

  task automatic pulse_out;
    ld_out_n = 1'b0; wclk(6); ld_out_n = 1'b1; wclk(6);
  endtask

  task automatic t_reset_zero;
    rst_mid = 1'b0; rst_n = 1'b0; wclk(4);
    chk_all(12'h000, 12'h000, 12'h000, 12'h000, "R1 reset zero-scale");
    rst_n = 1'b1; wclk(4);
    chk_all(12'h000, 12'h000, 12'h000, 12'h000, "R1 after release");
  endtask

  task automatic t_load_all;
    send(16'h0123); pulse_in;
    send(16'h1456); pulse_in;
    send(16'h2789); pulse_in;
    send(16'h3ABC); pulse_in;
    chk_all(12'h000, 12'h000, 12'h000, 12'h000, "R7 outputs hold until strobe");
    pulse_out;
    chk_all(12'h123, 12'h456, 12'h789, 12'hABC, "R3 R5 R7 simultaneous update");
  endtask

  task automatic t_ignored_bits;
    send(16'hE5A5); pulse_in; pulse_out;
    chk_all(12'h123, 12'h456, 12'h5A5, 12'hABC, "R3 top bits ignored");
  endtask

  task automatic t_cs_high;
    send(16'h0F0F);
    sdi = 1'b1;
    for (int k = 0; k < 5; k++) begin
      wclk(4); sclk = 1'b1; wclk(4); sclk = 1'b0;
    end
    wclk(20);
    pulse_in; pulse_out;
    chk_all(12'hF0F, 12'h456, 12'h5A5, 12'hABC, "R4 word kept with cs high");
  endtask

  task automatic t_in_hold;
    send(16'h1DEF); pulse_out;
    chk_all(12'hF0F, 12'h456, 12'h5A5, 12'hABC, "R6 input hold");
  endtask

  task automatic t_flow;
    send(16'h3321);
    ld_out_n = 1'b0;
    ld_in_n = 1'b0;
    wclk(4);
    chk(dac_code[47:36], 12'h321, "R8 flow-through by fourth edge");
    ld_in_n = 1'b1; ld_out_n = 1'b1; wclk(6);
    chk(dac_code[11:0], 12'hF0F, "R5 others untouched in flow-through");
  endtask

  task automatic t_reset_mid;
    rst_mid = 1'b1; wclk(2);
    #1 rst_n = 1'b0;
    #1 chk_all(12'h800, 12'h800, 12'h800, 12'h800, "R2 async mid-scale");
    wclk(3);
    rst_n = 1'b1; wclk(4);
    pulse_out;
    chk_all(12'h800, 12'h800, 12'h800, 12'h800, "R2 input regs mid-scale");
  endtask

  task automatic t_reset_zero_async;
    rst_mid = 1'b0; wclk(2);
    #1 rst_n = 1'b0;
    #1 chk_all(12'h000, 12'h000, 12'h000, 12'h000, "R1 async zero-scale");
    wclk(3); rst_n = 1'b1; wclk(4);
  endtask

  initial begin
    rst_n = 1'b0; rst_mid = 1'b0; sclk = 1'b0; sdi = 1'b0;
    cs_n = 1'b1; ld_in_n = 1'b1; ld_out_n = 1'b1;
    wclk(3);
    t_reset_zero;
    t_load_all;
    t_ignored_bits;
    t_cs_high;
    t_in_hold;
    t_flow;
    t_reset_mid;
    t_reset_zero_async;
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule